// File: doc/BRIEF.md
# Execution-Mask Control Unit

This unit owns the lane-enable mask of a group of vector lanes that run one instruction stream in lockstep. When a branch condition splits the lanes, the scalar side issues structured commands: open an if, swap to the else side, close the region, accumulate loop breaks, and close a loop iteration. The unit applies each command to the live mask. It returns a result mask, which the caller keeps in a scalar register and passes back later as the saved operand. The caller, not this unit, holds those saved masks. In the bench they live on a small software stack.

Each accepted command updates the live mask and the result register on the same clock edge. One edge later a response strobe rises for a single cycle, together with two branch hints. One hint says that no lane is live after an if or else, so the caller may jump over the region. The other says that lanes remain after a loop step, so the caller takes the back-edge. The mask can also be loaded directly, or built from a lane count packed inside a 32-bit word. A mode pin selects 64 lanes or the low 32 lanes.

Top module: `lane_mask_ctrl`

## Requirements
- R1: While reset is high the live mask becomes all ones over the selected lane count (64, or the low 32 in narrow mode), and the response strobe and both hints are low.
- R2: In narrow mode (wave32 high), bits 63..32 of the live mask and of the result mask always read zero.
- R3: IF (op 0) leaves live = live AND cond. The result is the set of lanes that were live before and are now off.
- R4: ELSE (op 1) first forms t = live OR saved. The result is t AND the old live mask, and the new live mask is t XOR result. The lanes that were waiting replace the lanes that were active.
- R5: END_CF (op 2) sets live = live OR saved, and the result equals the new live mask.
- R6: IF_BREAK (op 3) leaves the live mask unchanged. Its result is (live AND cond) OR saved. When cond_premasked is high, the AND is skipped and the result is cond OR saved.
- R7: LOOP (op 4) sets live = live AND NOT saved, and the result equals the new live mask.
- R8: INIT_IMM (op 5) loads the live mask from the saved operand, limited to the selected lanes. The result equals the new mask.
- R9: INIT_FROM_COUNT (op 6) works in three steps:
  - It forms an offset: cnt_shift AND (2*lanes-1), that is 127 in wide mode and 63 in narrow mode.
  - It reads a 7-bit count from cnt_word at that offset. Bits above bit 31 read as zero.
  - It sets the live mask to ones in lanes 0..count-1. A count at or above the lane count gives all lanes.
- R10: The live mask and the result change on the edge that accepts the command. rsp_valid is low after that edge, high for exactly one cycle after the next edge, and low again one edge later if no further command is accepted.
- R11: hint_exec_zero is high only with rsp_valid, after IF or ELSE, when the live mask is zero. hint_exec_nonzero is high only with rsp_valid, after LOOP, when the live mask is nonzero. Both hints are low for every other command.
- R12: A cycle with cmd_valid low, or with op 7, changes neither mask and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wave32 | input | 1 | High selects 32-lane operation |
| cmd_valid | input | 1 | Command qualifier |
| cmd_op | input | 3 | Command code (0 IF, 1 ELSE, 2 END_CF, 3 IF_BREAK, 4 LOOP, 5 INIT_IMM, 6 INIT_FROM_COUNT, 7 none) |
| cond_premasked | input | 1 | IF_BREAK condition already limited to live lanes |
| cmd_cond | input | 64 | Per-lane condition vector |
| cmd_saved | input | 64 | Saved-mask, break-mask or immediate operand |
| cnt_word | input | 32 | Word holding a packed lane count |
| cnt_shift | input | 7 | Bit offset of the count inside cnt_word |
| exec_mask | output | 64 | Live lane-enable mask |
| result_mask | output | 64 | Result of the last accepted command |
| rsp_valid | output | 1 | Response strobe, one cycle |
| hint_exec_zero | output | 1 | No lane live after IF or ELSE |
| hint_exec_nonzero | output | 1 | Lanes remain after LOOP |

## Verification
The assertions assume that the wave32 pin changes only while reset is held. The narrow-mode and stability properties compare masks across edges, so a mode flip in mid-run would break them. The bench switches modes only inside a reset pulse. Saved operands always come from the stack of earlier results or from table constants, so nesting stays well formed. The bench also issues at most one command every two cycles, which keeps each response aligned with the command that caused it.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [2:0] {
    OP_IF    = 3'd0,
    OP_ELSE  = 3'd1,
    OP_ENDCF = 3'd2,
    OP_BRK   = 3'd3,
    OP_LOOP  = 3'd4,
    OP_IMM   = 3'd5,
    OP_CNT   = 3'd6,
    OP_NONE  = 3'd7
  } lmc_op_e;
endpackage

// File: rtl/lmc_lane_fill.sv
module lmc_lane_fill #(
  parameter int MAX_LANES = 64
) (
  input  logic                 wave32,
  output logic [MAX_LANES-1:0] lane_en
);
  localparam int HALF = MAX_LANES / 2;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    if (i < HALF) begin : g_low
      assign lane_en[i] = 1'b1;
    end else begin : g_high
      assign lane_en[i] = ~wave32;
    end
  end
endmodule

// File: rtl/lmc_count_decode.sv
module lmc_count_decode #(
  parameter int MAX_LANES = 64,
  parameter int WORD_W    = 32,
  parameter int CNT_W     = 7,
  parameter int SHIFT_W   = $clog2(2 * MAX_LANES)
) (
  input  logic                 wave32,
  input  logic [MAX_LANES-1:0] lane_en,
  input  logic [WORD_W-1:0]    cnt_word,
  input  logic [SHIFT_W-1:0]   cnt_shift,
  output logic [MAX_LANES-1:0] cnt_mask,
  output logic                 cnt_full
);
  localparam logic [SHIFT_W-1:0] OFF_WIDE   = SHIFT_W'(2 * MAX_LANES - 1);
  localparam logic [SHIFT_W-1:0] OFF_NARROW = SHIFT_W'(MAX_LANES - 1);
  localparam logic [CNT_W-1:0]   N_WIDE     = CNT_W'(MAX_LANES);
  localparam logic [CNT_W-1:0]   N_NARROW   = CNT_W'(MAX_LANES / 2);

  logic [SHIFT_W-1:0] offset;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   lanes_n;

  function automatic logic [CNT_W-1:0] f_extract(input logic [WORD_W-1:0] w,
                                                 input logic [SHIFT_W-1:0] o);
    return CNT_W'(w >> o);
  endfunction

  function automatic logic [MAX_LANES-1:0] f_run(input logic [CNT_W-1:0] n);
    return ~({MAX_LANES{1'b1}} << n);
  endfunction

  always_comb begin
    offset   = cnt_shift & (wave32 ? OFF_NARROW : OFF_WIDE);
    count    = f_extract(cnt_word, offset);
    lanes_n  = wave32 ? N_NARROW : N_WIDE;
    cnt_full = (count >= lanes_n);
    cnt_mask = cnt_full ? lane_en : (f_run(count) & lane_en);
  end

  always_comb begin
    AST_RUN_CONTIGUOUS: assert ((cnt_mask & (cnt_mask + 1'b1)) == '0);  // R9
  end
endmodule

// File: rtl/lmc_mask_alu.sv
module lmc_mask_alu
  import lmc_pkg::*;
#(
  parameter int MAX_LANES = 64
) (
  input  lmc_op_e              op,
  input  logic                 premasked,
  input  logic [MAX_LANES-1:0] lane_en,
  input  logic [MAX_LANES-1:0] live,
  input  logic [MAX_LANES-1:0] cond,
  input  logic [MAX_LANES-1:0] saved,
  input  logic [MAX_LANES-1:0] cnt_mask,
  output logic [MAX_LANES-1:0] nxt_live,
  output logic [MAX_LANES-1:0] nxt_res,
  output logic                 else_swap
);
  typedef logic [MAX_LANES-1:0] mask_t;

  mask_t e, c, s, t_or;

  function automatic mask_t f_if_live(mask_t l, mask_t k);
    return l & k;
  endfunction

  function automatic mask_t f_brk(mask_t l, mask_t k, mask_t prev, logic pm);
    return (pm ? k : (l & k)) | prev;
  endfunction

  always_comb begin
    e    = live & lane_en;
    c    = cond & lane_en;
    s    = saved & lane_en;
    t_or = e | s;
    nxt_live  = e;
    nxt_res   = e;
    else_swap = 1'b0;
    unique case (op)
      OP_IF: begin
        nxt_live = f_if_live(e, c);
        nxt_res  = nxt_live ^ e;
      end
      OP_ELSE: begin
        nxt_res   = t_or & e;
        nxt_live  = t_or ^ nxt_res;
        else_swap = 1'b1;
      end
      OP_ENDCF: begin
        nxt_live = t_or;
        nxt_res  = t_or;
      end
      OP_BRK: begin
        nxt_live = e;
        nxt_res  = f_brk(e, c, s, premasked);
      end
      OP_LOOP: begin
        nxt_live = e & ~s;
        nxt_res  = nxt_live;
      end
      OP_IMM: begin
        nxt_live = s;
        nxt_res  = s;
      end
      OP_CNT: begin
        nxt_live = cnt_mask;
        nxt_res  = cnt_mask;
      end
      default: begin
        nxt_live = e;
        nxt_res  = e;
      end
    endcase
  end

  always_comb begin
    if (else_swap) begin
      AST_ELSE_DISJOINT: assert ((nxt_live & nxt_res) == '0);  // R4
    end
  end
endmodule

// File: rtl/lmc_resp_stage.sv
module lmc_resp_stage
  import lmc_pkg::*;
#(
  parameter int MAX_LANES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc,
  input  lmc_op_e              op,
  input  logic [MAX_LANES-1:0] live,
  output logic                 rsp_valid,
  output logic                 hint_zero,
  output logic                 hint_nonzero
);
  logic    pend_q;
  lmc_op_e pend_op_q;
  logic    live_none;
  logic    want_zero_hint;
  logic    want_loop_hint;

  assign live_none      = (live == '0);
  assign want_zero_hint = (pend_op_q == OP_IF) || (pend_op_q == OP_ELSE);
  assign want_loop_hint = (pend_op_q == OP_LOOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      pend_op_q    <= OP_NONE;
      rsp_valid    <= 1'b0;
      hint_zero    <= 1'b0;
      hint_nonzero <= 1'b0;
    end else begin
      pend_q       <= acc;
      pend_op_q    <= op;
      rsp_valid    <= pend_q;
      hint_zero    <= pend_q && want_zero_hint && live_none;
      hint_nonzero <= pend_q && want_loop_hint && !live_none;
    end
  end

  AST_RSP_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 rsp_valid);  // R10
  AST_HINTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(hint_zero && hint_nonzero));  // R11
  AST_HINT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    (hint_zero || hint_nonzero) |-> rsp_valid);  // R11
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lmc_pkg::*;
#(
  parameter int MAX_LANES = 64,
  parameter int WORD_W    = 32,
  parameter int CNT_W     = 7,
  localparam int SHIFT_W  = $clog2(2 * MAX_LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wave32,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic                 cond_premasked,
  input  logic [MAX_LANES-1:0] cmd_cond,
  input  logic [MAX_LANES-1:0] cmd_saved,
  input  logic [WORD_W-1:0]    cnt_word,
  input  logic [SHIFT_W-1:0]   cnt_shift,
  output logic [MAX_LANES-1:0] exec_mask,
  output logic [MAX_LANES-1:0] result_mask,
  output logic                 rsp_valid,
  output logic                 hint_exec_zero,
  output logic                 hint_exec_nonzero
);
  localparam int HALF = MAX_LANES / 2;

  lmc_op_e              op;
  logic                 acc;
  logic [MAX_LANES-1:0] lane_en;
  logic [MAX_LANES-1:0] cnt_mask;
  logic                 cnt_full;
  logic [MAX_LANES-1:0] nxt_live;
  logic [MAX_LANES-1:0] nxt_res;
  logic                 else_swap;
  logic [MAX_LANES-1:0] exec_q;
  logic [MAX_LANES-1:0] res_q;

  assign op  = lmc_op_e'(cmd_op);
  assign acc = cmd_valid && (op != OP_NONE);

  lmc_lane_fill #(.MAX_LANES(MAX_LANES)) u_fill (
    .wave32  (wave32),
    .lane_en (lane_en)
  );

  lmc_count_decode #(
    .MAX_LANES (MAX_LANES),
    .WORD_W    (WORD_W),
    .CNT_W     (CNT_W),
    .SHIFT_W   (SHIFT_W)
  ) u_cnt (
    .wave32    (wave32),
    .lane_en   (lane_en),
    .cnt_word  (cnt_word),
    .cnt_shift (cnt_shift),
    .cnt_mask  (cnt_mask),
    .cnt_full  (cnt_full)
  );

  lmc_mask_alu #(.MAX_LANES(MAX_LANES)) u_alu (
    .op        (op),
    .premasked (cond_premasked),
    .lane_en   (lane_en),
    .live      (exec_q),
    .cond      (cmd_cond),
    .saved     (cmd_saved),
    .cnt_mask  (cnt_mask),
    .nxt_live  (nxt_live),
    .nxt_res   (nxt_res),
    .else_swap (else_swap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q <= lane_en;
      res_q  <= '0;
    end else if (acc) begin
      exec_q <= nxt_live;
      res_q  <= nxt_res;
    end
  end

  lmc_resp_stage #(.MAX_LANES(MAX_LANES)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .acc          (acc),
    .op           (op),
    .live         (exec_q),
    .rsp_valid    (rsp_valid),
    .hint_zero    (hint_exec_zero),
    .hint_nonzero (hint_exec_nonzero)
  );

  assign exec_mask   = exec_q;
  assign result_mask = res_q;

  AST_NARROW_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wave32 |-> (exec_q[MAX_LANES-1:HALF] == '0 && res_q[MAX_LANES-1:HALF] == '0));  // R2
  AST_IF_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_IF) |=> ((exec_q & ~$past(exec_q)) == '0));  // R3
  AST_ENDCF_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_ENDCF) |=> ((exec_q & $past(exec_q)) == $past(exec_q)));  // R5
  AST_BRK_HOLDS_LIVE: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_BRK) |=> $stable(exec_q));  // R6
  AST_LOOP_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_LOOP) |=> ((exec_q & ~$past(exec_q)) == '0));  // R7
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_CNT && cnt_full) |=> (exec_q == $past(lane_en)));  // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(exec_q) && $stable(res_q)));  // R12
endmodule

// File: tb/tb_lane_mask_ctrl.sv
module tb_lane_mask_ctrl;
  localparam int ML = 64;

  typedef struct packed {
    logic [2:0]  op;
    logic        prem;
    logic        pop;
    logic        push;
    logic [63:0] cond;
    logic [63:0] saved;
    logic [31:0] word;
    logic [6:0]  shift;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd0, 1'b0, 1'b0, 1'b1, 64'h00FF_00FF_F0F0_1234, 64'h0, 32'h0, 7'd0},
    '{3'd0, 1'b0, 1'b0, 1'b1, 64'h0F0F_0F0F_0FF0_FF00, 64'h0, 32'h0, 7'd0},
    '{3'd1, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd2, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd1, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd2, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd0, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd2, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd3, 1'b0, 1'b0, 1'b1, 64'h8000_0001_0000_00F1, 64'h0, 32'h0, 7'd0},
    '{3'd4, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 7'd0},
    '{3'd3, 1'b1, 1'b0, 1'b0, 64'h0000_0300_0000_0006, 64'h1, 32'h0, 7'd0},
    '{3'd4, 1'b0, 1'b0, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 7'd0},
    '{3'd5, 1'b0, 1'b0, 1'b0, 64'h0, 64'hDEAD_BEEF_0123_4567, 32'h0, 7'd0},
    '{3'd6, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_0A00, 7'd8},
    '{3'd6, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_0400, 7'd4},
    '{3'd6, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_0800, 7'd70},
    '{3'd5, 1'b0, 1'b0, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 7'd0},
    '{3'd4, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_000F, 32'h0, 7'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wave32 = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd7;
  logic          cond_premasked = 1'b0;
  logic [ML-1:0] cmd_cond = '0;
  logic [ML-1:0] cmd_saved = '0;
  logic [31:0]   cnt_word = '0;
  logic [6:0]    cnt_shift = '0;
  logic [ML-1:0] exec_mask, result_mask;
  logic          rsp_valid, hint_exec_zero, hint_exec_nonzero;

  always #2 clk = ~clk;

  lane_mask_ctrl dut (
    .clk(clk), .rst(rst), .wave32(wave32), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cond_premasked(cond_premasked), .cmd_cond(cmd_cond), .cmd_saved(cmd_saved),
    .cnt_word(cnt_word), .cnt_shift(cnt_shift), .exec_mask(exec_mask),
    .result_mask(result_mask), .rsp_valid(rsp_valid),
    .hint_exec_zero(hint_exec_zero), .hint_exec_nonzero(hint_exec_nonzero)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [ML-1:0] m_exec, m_res;
  logic [ML-1:0] stk [0:7];
  int sp = 0;

  task automatic chk(input string req, input logic [ML-1:0] act, input logic [ML-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3 IF";
      3'd1: return "R4 ELSE";
      3'd2: return "R5 END_CF";
      3'd3: return "R6 IF_BREAK";
      3'd4: return "R7 LOOP";
      3'd5: return "R8 INIT_IMM";
      default: return "R9 INIT_FROM_COUNT";
    endcase
  endfunction

  function automatic int lanes_of(input logic w);
    return w ? 32 : 64;
  endfunction

  // lane-by-lane restatement of the requirements
  task automatic model(input logic [2:0] op, input logic pm, input logic [ML-1:0] c,
                       input logic [ML-1:0] s, input logic [31:0] w, input logic [6:0] sh);
    int L = lanes_of(wave32);
    int off = sh % (2 * L);
    int cnt = int'((w >> off) & 32'h7F);
    logic [ML-1:0] n = '0;
    logic [ML-1:0] r = '0;
    for (int i = 0; i < L; i++) begin
      logic e = m_exec[i];
      case (op)
        3'd0: begin n[i] = e & c[i]; r[i] = e & ~c[i]; end
        3'd1: begin n[i] = s[i] & ~e; r[i] = e; end
        3'd2: begin n[i] = e | s[i]; r[i] = n[i]; end
        3'd3: begin n[i] = e; r[i] = (pm ? c[i] : (e & c[i])) | s[i]; end
        3'd4: begin n[i] = e & ~s[i]; r[i] = n[i]; end
        3'd5: begin n[i] = s[i]; r[i] = s[i]; end
        default: begin n[i] = (i < cnt); r[i] = n[i]; end
      endcase
    end
    m_exec = n;
    m_res  = r;
  endtask

  task automatic do_reset(input logic w);
    @(negedge clk);
    rst = 1'b1; wave32 = w; cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_exec = w ? {32'h0, 32'hFFFF_FFFF} : '1;
    m_res = '0;
    sp = 0;
    chk("R1 reset mask", exec_mask, m_exec);
    chk("R1 reset strobe", {61'b0, rsp_valid, hint_exec_zero, hint_exec_nonzero}, '0);
  endtask

  // drive at a falling edge, accept on the next rising edge
  task automatic issue(input vec_t v);
    logic [ML-1:0] s = v.saved;
    logic ez, enz;
    if (v.pop) begin sp--; s = stk[sp]; end
    cmd_valid = 1'b1; cmd_op = v.op; cond_premasked = v.prem;
    cmd_cond = v.cond; cmd_saved = s; cnt_word = v.word; cnt_shift = v.shift;
    model(v.op, v.prem, v.cond, s, v.word, v.shift);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
    chk({req_of(v.op), " exec"}, exec_mask, m_exec);
    chk({req_of(v.op), " result"}, result_mask, m_res);
    chk("R10 no strobe yet", {63'b0, rsp_valid}, '0);
    if (wave32) chk("R2 high half", {exec_mask[63:32], result_mask[63:32]}, '0);
    if (v.push) begin stk[sp] = m_res; sp++; end
    ez  = (v.op == 3'd0 || v.op == 3'd1) && (m_exec == '0);
    enz = (v.op == 3'd4) && (m_exec != '0);
    @(negedge clk);
    chk("R11 strobe and hints", {61'b0, rsp_valid, hint_exec_zero, hint_exec_nonzero},
        {61'b0, 1'b1, ez, enz});
  endtask

  task automatic run_table(input logic w);
    do_reset(w);
    for (int k = 0; k < NV; k++) issue(VECS[k]);
  endtask

  initial begin
    vec_t d;
    @(negedge clk);
    run_table(1'b0);
    run_table(1'b1);

    // R10: strobe lasts exactly one cycle
    do_reset(1'b0);
    d = '{3'd0, 1'b0, 1'b0, 1'b0, 64'h0000_FFFF_0000_FFFF, 64'h0, 32'h0, 7'd0};
    issue(d);
    @(negedge clk);
    chk("R10 strobe drops", {63'b0, rsp_valid}, '0);

    // R12: invalid and op 7 cycles change nothing
    cmd_valid = 1'b0; cmd_op = 3'd5; cmd_saved = 64'h1234;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7; cmd_saved = 64'h5678;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12 exec kept", exec_mask, m_exec);
    chk("R12 result kept", result_mask, m_res);
    @(negedge clk);
    chk("R12 no strobe", {63'b0, rsp_valid}, '0);
    @(negedge clk);
    chk("R12 no strobe later", {63'b0, rsp_valid}, '0);

    // R9: count above the lane count saturates in both modes
    d = '{3'd6, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_4100, 7'd8};
    issue(d);
    chk("R9 count 65 wide", exec_mask, '1);
    do_reset(1'b1);
    d = '{3'd6, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_001F, 7'd64};
    issue(d);
    chk("R9 narrow offset wraps", exec_mask, 64'h0000_0000_7FFF_FFFF);
    d = '{3'd6, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_2100, 7'd8};
    issue(d);
    chk("R9 count 33 narrow", exec_mask, 64'h0000_0000_FFFF_FFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule